// File: doc/BRIEF.md
# Time-Multiplexed Multiply-Accumulate FIR Filter

This block is a single-channel FIR filter with a fixed set of taps. It uses four multipliers that it reuses over several clock cycles to build each output. Every accepted input sample is written into a circular sample store. The store is split into four banks, and each bank has its own read and write address. After each write, a small sequencer makes one pass per clock over the history. In each pass it reads four samples and four coefficients, and it multiplies the pairs. The four products are summed into one partial result. This partial result either starts a fresh accumulation, on the first pass, or is added to the running total, on the later passes. After the final pass, the total is copied into the output register and flagged for one cycle.

The coefficients are fixed when the block is built. They are given as a parameter vector, tap `j` occupying bits `[j*CW +: CW]`. Coefficient 0 multiplies the newest sample. If the tap count is not a multiple of four, the missing coefficients in the last pass are zero. A producer offers samples with a valid/ready handshake. The consumer receives a 44-bit result together with a one-cycle valid pulse.

Top module: `fir_mac_tdm`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. Reset also clears the sample history to zero.
- R2: For each accepted sample `x[n]`, the result is `sum over j<TAPS of c[j]*x[n-j]`. Data and coefficients are signed two's complement, and the result is a signed 44-bit value. A sample older than the history since reset counts as zero.
- R3: With `P = ceil(TAPS/4)`, `out_valid` is high exactly `P+2` clock edges after the edge that accepted the sample. When input is continuous, one result is produced every `P` cycles.
- R4: `in_ready` is 1 when the block is idle or in the final pass of the current result, and 0 in every other pass. When `in_valid` is high while `in_ready` is low, the sample is ignored and never enters the history.
- R5: `out_valid` lasts one cycle. `out_data` keeps its value until the next pulse.
- R6: Each result starts from a cleared accumulator, so no part of the previous result carries into the next.
- R7: The history is a circular buffer whose write position advances once per accepted sample. Results stay correct after the buffer has wrapped many times.
- R8: Coefficient `j` is taken from bits `[j*CW +: CW]` of `COEFS` and multiplies the sample `j` steps old. An impulse input therefore produces the coefficients in order, from `c[0]` upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample is offered |
| in_data | input | DW (18) | Signed input sample |
| in_ready | output | 1 | The block takes the offered sample at this edge |
| out_valid | output | 1 | One-cycle pulse when a new result is loaded |
| out_data | output | OW (44) | Signed filter result |

## Verification
The assertions assume that `rst_n` is low on the first clock edge. They also assume that `in_valid` and `in_data` change only away from the rising edge, so the ready/valid decision is stable at each edge. The assertions do not assume that the producer waits for `in_ready`. The stimulus deliberately holds `in_valid` high and changes `in_data` on every cycle while the block is busy. In that case only the samples offered while ready are expected to appear in the results. The bench runs a small filter: ten taps, giving three passes and two padded coefficient slots. It feeds impulses, extreme values of both signs, and pseudo-random sequences with gaps. This is enough for the history to wrap many times.

// File: rtl/fir_mac_tdm.sv
module fir_mac_tdm #(
  parameter int TAPS  = 100,
  parameter int MULTS = 4,
  parameter int DW    = 18,
  parameter int CW    = 18,
  parameter int OW    = 44,
  parameter logic [TAPS*CW-1:0] COEFS = {TAPS{{(CW-1){1'b0}}, 1'b1}}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int PASSES = (TAPS + MULTS - 1) / MULTS;
  localparam int DEPTH  = PASSES * MULTS;
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam int WW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BW     = (MULTS > 1) ? $clog2(MULTS) : 1;
  localparam int PRW    = DW + CW;

  logic signed [CW-1:0] crom [PASSES][MULTS];

  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    for (genvar m = 0; m < MULTS; m++) begin : g_mul
      if (p * MULTS + m < TAPS) begin : g_tap
        assign crom[p][m] = COEFS[(p*MULTS+m)*CW +: CW];
      end else begin : g_pad
        assign crom[p][m] = '0;
      end
    end
  end

  logic                 busy;
  logic [PW-1:0]        pass;
  logic [WW-1:0]        wp;
  logic signed [DW-1:0] mem [MULTS][PASSES];
  logic [PW-1:0]        raddr [MULTS];
  logic [BW-1:0]        sel [MULTS];
  logic [BW-1:0]        wbank;
  logic [PW-1:0]        waddr;

  wire last_pass = busy && (pass == PW'(PASSES - 1));
  wire accept    = in_valid && in_ready;
  assign in_ready = !busy || last_pass;
  assign wbank = BW'(int'(wp) % MULTS);
  assign waddr = PW'(int'(wp) / MULTS);

  always_comb begin
    int newest;
    int idx;
    newest = (wp == '0) ? DEPTH - 1 : int'(wp) - 1;
    for (int b = 0; b < MULTS; b++) raddr[b] = '0;
    for (int m = 0; m < MULTS; m++) begin
      idx = (newest + DEPTH - int'(pass) * MULTS - m) % DEPTH;
      sel[m] = BW'(idx % MULTS);
      raddr[idx % MULTS] = PW'(idx / MULTS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pass <= '0;
      wp   <= '0;
      for (int b = 0; b < MULTS; b++)
        for (int a = 0; a < PASSES; a++)
          mem[b][a] <= '0;
    end else if (accept) begin
      mem[wbank][waddr] <= in_data;
      wp   <= (wp == WW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      busy <= 1'b1;
      pass <= '0;
    end else if (last_pass) begin
      busy <= 1'b0;
      pass <= '0;
    end else if (busy) begin
      pass <= pass + 1'b1;
    end
  end

  logic signed [DW-1:0] bank_q [MULTS];
  logic [BW-1:0]        sel_q  [MULTS];
  logic signed [CW-1:0] cf_q   [MULTS];
  logic                 s1_vld, s1_first, s1_last;

  always_ff @(posedge clk) begin
    for (int m = 0; m < MULTS; m++) begin
      bank_q[m] <= mem[m][raddr[m]];
      sel_q[m]  <= sel[m];
      cf_q[m]   <= crom[pass][m];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_vld   <= busy;
      s1_first <= busy && (pass == '0);
      s1_last  <= last_pass;
    end
  end

  logic signed [OW-1:0] psum;
  always_comb begin
    logic signed [PRW-1:0] prod;
    psum = '0;
    for (int m = 0; m < MULTS; m++) begin
      prod = bank_q[sel_q[m]] * cf_q[m];
      psum = psum + OW'(prod);
    end
  end

  logic signed [OW-1:0] acc;
  logic                 s2_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      s2_last <= 1'b0;
    end else begin
      if (s1_vld) acc <= s1_first ? psum : acc + psum;
      s2_last <= s1_vld && s1_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s2_last;
      if (s2_last) out_data <= acc;
    end
  end
endmodule

module fir_mac_tdm_chk #(
  parameter int PASSES = 25,
  parameter int DW     = 18,
  parameter int OW     = 44
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          in_ready,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready && out_data == '0));

  assert_busy_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && PASSES > 1) |=> !in_ready);

  assert_idle_stays_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> in_ready);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && PASSES > 1) |=> !out_valid);

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind fir_mac_tdm fir_mac_tdm_chk #(.PASSES(PASSES), .DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

// File: tb/test_fir_mac_tdm.sv
`timescale 1ns/1ps
module test_fir_mac_tdm;
  localparam int TAPS = 10;
  localparam int P    = (TAPS + 3) / 4;

  function automatic logic [TAPS*18-1:0] mk_coefs();
    logic [TAPS*18-1:0] v;
    v = '0;
    for (int j = 0; j < TAPS; j++) begin
      int c;
      if (j == 0) c = 131071;
      else if (j == 1) c = -131072;
      else c = j * 5003 - 30011;
      v[j*18 +: 18] = 18'(c);
    end
    return v;
  endfunction

  localparam logic [TAPS*18-1:0] TB_COEFS = mk_coefs();

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [17:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [43:0] out_data;

  fir_mac_tdm #(.TAPS(TAPS), .COEFS(TB_COEFS)) i_fir_mac_tdm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, rem = 0;
  longint hist[$];
  longint exp_val[$];
  int     exp_cyc[$];
  longint last_out = 0;
  logic   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coef(int j);
    return longint'($signed(TB_COEFS[j*18 +: 18]));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
      chk(out_valid == 1'b1, "R3 out_valid timing", longint'(out_valid), 1);
      chk(longint'(out_data) == exp_val[0], "R2/R6/R7/R8 result", longint'(out_data), exp_val[0]);
      last_out = longint'(out_data);
      void'(exp_cyc.pop_front());
      void'(exp_val.pop_front());
    end else begin
      chk(out_valid == 1'b0, "R5 no stray pulse", longint'(out_valid), 0);
      chk(longint'(out_data) == last_out, "R5 result held", longint'(out_data), last_out);
    end
  end

  task automatic step(bit v, logic signed [17:0] d);
    bit took;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    chk(in_ready == (rem <= 1), "R4 ready", longint'(in_ready), longint'(rem <= 1));
    took = v && in_ready;
    if (took) begin
      longint s;
      hist.push_front(longint'(d));
      s = 0;
      for (int j = 0; j < TAPS && j < hist.size(); j++) s += coef(j) * hist[j];
      exp_val.push_back(s);
      exp_cyc.push_back(cyc + 1 + P + 2);
    end
    @(posedge clk);
    if (took) rem = P;
    else if (rem > 0) rem--;
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", longint'(out_valid), 0);
    chk(out_data == 0, "R1 out_data", longint'(out_data), 0);
    chk(in_ready == 1, "R1 in_ready", longint'(in_ready), 1);
    rst_n = 1;

    // R8 impulse, valid held high, data changing while busy (R4 ignore)
    step(1, 18'sd1);
    for (int i = 0; i < 3 * TAPS * P; i++) step(1, (i % P == P - 1) ? 18'sd0 : 18'sd777);
    for (int i = 0; i < 8; i++) step(0, 18'sd0);

    // R2 extreme values
    for (int i = 0; i < TAPS + 2; i++) step(1, -18'sd131072);
    for (int i = 0; i < TAPS + 2; i++) step(1, 18'sd131071);
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 18'sd131071 : -18'sd131072);

    // R7 pseudo-random with gaps, many wraps
    lfsr = 18'h2A5F3;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
      step(lfsr[3] | lfsr[7], $signed(lfsr));
    end

    for (int i = 0; i < P + 6; i++) step(0, 18'sd0);
    chk(exp_cyc.size() == 0, "R3 all results delivered", exp_cyc.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule